// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block holds two 8-line interrupt priority resolvers, a primary and a secondary, chained together. A pending request on the secondary lights the request bit of primary line 2, so the secondary's lines reach the processor through that single primary input. Each resolver keeps a request register and an in-service register. It offers a line to the processor only when the line is unmasked and ranks above every line already in service. Line 0 ranks highest.

When the processor strobes an acknowledge, the block resolves the primary. If line 2 wins, it also resolves the secondary. It marks the winners in service and registers an 8-bit vector, formed from a vector base input and the line number. Spurious cases report line 7. A poll read returns the pending line of either resolver and retires it at once, without putting it in service. A non-specific end-of-service strobe retires the highest-ranked in-service line of the resolver it selects. Register decoding for a bus is outside the block: masks, trigger modes and bases arrive as inputs.

Top module: `cascade_ack_seq`

## Requirements
- R1: While `rst_n` is low and right after it rises, `int_out` is 0 and `vector` and `poll_data` are 0x00. Every request, in-service and previous-level bit is cleared.
- R2: On an edge-mode line, a rising input sets that line's request bit. `int_out` is 1 only when some unmasked request (`irq_mask` bit 1 = masked) has a lower line index than every in-service line of the primary.
- R3: A line in level mode (`level_mode` bit 1) has a request bit that follows its input. Acknowledge does not clear it. Level mode is honoured only on primary lines 3 to 7 and secondary lines 1, 2, 3, 4, 6 and 7; all other lines are always edge mode.
- R4: While the secondary has a winning request, primary line 2 becomes pending one cycle later. `irq_in[2]` and `level_mode[2]` have no effect.
- R5: An acknowledge with a primary winner other than line 2 sets that line in service and clears its request bit if it is edge mode. One cycle after the strobe, `vector` equals (`master_base` AND 0xF8) OR line.
- R6: An acknowledge whose primary winner is line 2 also puts the secondary winner in service. The vector is (`slave_base` AND 0xF8) OR secondary line.
- R7: If primary line 2 is taken while the secondary has no winner, the vector is (`slave_base` AND 0xF8) OR 7, and the secondary's state is left unchanged.
- R8: An acknowledge with no primary winner gives (`master_base` AND 0xF8) OR 7 and changes no in-service bit.
- R9: `vector` holds its value until the next acknowledge strobe.
- R10: A poll (`poll_slave` 0 = primary, 1 = secondary) that finds a winner returns 0x80 OR line and clears that line's request and in-service bits. A secondary poll also clears the primary line 2 request and in-service bits. A poll with no winner returns 0x07. `poll_data` is valid one cycle after the strobe and is held until the next poll.
- R11: `eoi_req` clears the lowest-index in-service bit of the resolver picked by `eoi_slave`.
- R12: In a cycle with several strobes, acknowledge is served first, then poll, then end-of-service. Strobes that lose are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request inputs; 7:0 primary, 15:8 secondary |
| level_mode | input | 16 | Per-line trigger mode, 1 = level |
| irq_mask | input | 16 | Per-line mask, 1 = masked |
| master_base | input | 8 | Primary vector base, low 3 bits ignored |
| slave_base | input | 8 | Secondary vector base, low 3 bits ignored |
| ack_req | input | 1 | Acknowledge strobe |
| poll_req | input | 1 | Poll read strobe |
| poll_slave | input | 1 | Poll target, 1 = secondary |
| eoi_req | input | 1 | Non-specific end-of-service strobe |
| eoi_slave | input | 1 | End-of-service target, 1 = secondary |
| int_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Acknowledge vector |
| poll_data | output | 8 | Poll result |

## Verification
The bench builds the block with its default level-mode allow masks, 0xF8 for the primary and 0xDE for the secondary, and the cascade on line 2. With these defaults, level behaviour is reachable on primary line 3. The same defaults let the bench confirm that primary line 0 stays edge mode even when `level_mode` asks for level mode. Cascaded acknowledges run through secondary lines 5 and 6, including the spurious path where the secondary request is masked after primary line 2 has latched. Vector bases with nonzero low bits show that those bits never reach the vector.

// File: rtl/cascade_ack_seq.sv
module cascade_ack_seq #(
  parameter logic [7:0] MASTER_LEVEL_OK = 8'hF8,
  parameter logic [7:0] SLAVE_LEVEL_OK  = 8'hDE,
  parameter int         CASCADE_LINE    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  input  logic [15:0] level_mode,
  input  logic [15:0] irq_mask,
  input  logic [7:0]  master_base,
  input  logic [7:0]  slave_base,
  input  logic        ack_req,
  input  logic        poll_req,
  input  logic        poll_slave,
  input  logic        eoi_req,
  input  logic        eoi_slave,
  output logic        int_out,
  output logic [7:0]  vector,
  output logic [7:0]  poll_data
);
  localparam logic [2:0] CL = 3'(CASCADE_LINE);

  function automatic logic [3:0] lowest(input logic [7:0] v);
    lowest = 4'd8;
    for (int i = 7; i >= 0; i--)
      if (v[i]) lowest = 4'(i);
  endfunction

  logic [7:0] m_irr, m_isr, m_last, s_irr, s_isr, s_last;
  logic [7:0] m_irr_n, m_isr_n, s_irr_n, s_isr_n;

  wire [7:0] m_lvl = level_mode[7:0] & MASTER_LEVEL_OK & ~(8'd1 << CL);
  wire [7:0] s_lvl = level_mode[15:8] & SLAVE_LEVEL_OK;

  wire [3:0] m_pick = lowest(m_irr & ~irq_mask[7:0]);
  wire [3:0] m_cur  = lowest(m_isr);
  wire [3:0] s_pick = lowest(s_irr & ~irq_mask[15:8]);
  wire [3:0] s_cur  = lowest(s_isr);
  wire       m_hit  = m_pick < m_cur;
  wire       s_hit  = s_pick < s_cur;

  wire [2:0] mline  = m_hit ? m_pick[2:0] : 3'd7;
  wire [2:0] sline  = s_hit ? s_pick[2:0] : 3'd7;
  wire       casc   = ack_req && m_hit && (m_pick[2:0] == CL);
  wire       poll_m = !ack_req && poll_req && !poll_slave;
  wire       poll_s = !ack_req && poll_req && poll_slave;
  wire       eoi_go = !ack_req && !poll_req && eoi_req;
  wire       m_cl_polled = poll_m && m_hit && (m_pick[2:0] == CL);

  assign int_out = m_hit;

  always_comb begin
    m_irr_n = m_irr;
    m_isr_n = m_isr;
    s_irr_n = s_irr;
    s_isr_n = s_isr;
    if (ack_req) begin
      if (m_hit) begin
        m_isr_n[mline] = 1'b1;
        if (!m_lvl[mline]) m_irr_n[mline] = 1'b0;
      end
      if (casc && s_hit) begin
        s_isr_n[sline] = 1'b1;
        if (!s_lvl[sline]) s_irr_n[sline] = 1'b0;
      end
    end else if (poll_s) begin
      if (s_hit) begin
        s_irr_n[sline] = 1'b0;
        s_isr_n[sline] = 1'b0;
        m_irr_n[CL]    = 1'b0;
        m_isr_n[CL]    = 1'b0;
      end
    end else if (poll_m) begin
      if (m_hit) begin
        m_irr_n[mline] = 1'b0;
        m_isr_n[mline] = 1'b0;
      end
    end else if (eoi_go) begin
      if (eoi_slave) begin
        if (s_cur < 4'd8) s_isr_n[s_cur[2:0]] = 1'b0;
      end else begin
        if (m_cur < 4'd8) m_isr_n[m_cur[2:0]] = 1'b0;
      end
    end
    for (int i = 0; i < 8; i++) begin
      if (s_lvl[i])                           s_irr_n[i] = irq_in[8+i];
      else if (irq_in[8+i] && !s_last[i])     s_irr_n[i] = 1'b1;
      if (i == int'(CL)) begin
        if (s_hit && !casc && !poll_s && !m_cl_polled) m_irr_n[i] = 1'b1;
      end else if (m_lvl[i])                  m_irr_n[i] = irq_in[i];
      else if (irq_in[i] && !m_last[i])       m_irr_n[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_irr     <= '0;
      m_isr     <= '0;
      m_last    <= '0;
      s_irr     <= '0;
      s_isr     <= '0;
      s_last    <= '0;
      vector    <= '0;
      poll_data <= '0;
    end else begin
      m_irr  <= m_irr_n;
      m_isr  <= m_isr_n;
      s_irr  <= s_irr_n;
      s_isr  <= s_isr_n;
      m_last <= irq_in[7:0];
      s_last <= irq_in[15:8];
      if (ack_req)
        vector <= casc ? ((slave_base & 8'hF8) | {5'd0, sline})
                       : ((master_base & 8'hF8) | {5'd0, mline});
      if (poll_m)
        poll_data <= m_hit ? {5'b10000, mline} : 8'h07;
      else if (poll_s)
        poll_data <= s_hit ? {5'b10000, sline} : 8'h07;
    end
  end
endmodule

// File: rtl/cascade_ack_seq_chk.sv
module cascade_ack_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_req,
  input logic       poll_req,
  input logic       int_out,
  input logic [7:0] vector,
  input logic [7:0] poll_data,
  input logic [7:0] m_isr
);
  AST_SPUR_LINE7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && !int_out |=> vector[2:0] == 3'd7); // R8
  AST_SPUR_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && !int_out |=> $stable(m_isr)); // R8
  AST_ACK_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && int_out |=> $countones(m_isr) == $past($countones(m_isr)) + 1); // R5
  AST_VECTOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> $stable(vector)); // R9
  AST_POLL_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req && !ack_req |=> (poll_data[7:3] == 5'b10000) || (poll_data == 8'h07)); // R10
  AST_POLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(poll_req && !ack_req) |=> $stable(poll_data)); // R12
endmodule

bind cascade_ack_seq cascade_ack_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .poll_req(poll_req),
  .int_out(int_out), .vector(vector), .poll_data(poll_data), .m_isr(m_isr)
);

// File: tb/tb_cascade_ack_seq.sv
module tb_cascade_ack_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] irq_in = '0, level_mode = '0, irq_mask = '0;
  logic [7:0] master_base = 8'h25, slave_base = 8'h71;
  logic ack_req = 0, poll_req = 0, poll_slave = 0, eoi_req = 0, eoi_slave = 0;
  logic int_out;
  logic [7:0] vector, poll_data;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  cascade_ack_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .irq_mask(irq_mask), .master_base(master_base), .slave_base(slave_base),
    .ack_req(ack_req), .poll_req(poll_req), .poll_slave(poll_slave),
    .eoi_req(eoi_req), .eoi_slave(eoi_slave), .int_out(int_out),
    .vector(vector), .poll_data(poll_data)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edge_line(input int idx);
    @(negedge clk) irq_in[idx] = 1'b1;
    @(negedge clk) irq_in[idx] = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk) ack_req = 1'b1;
    @(negedge clk) ack_req = 1'b0;
  endtask

  task automatic poll(input logic sl);
    @(negedge clk) begin poll_req = 1'b1; poll_slave = sl; end
    @(negedge clk) poll_req = 1'b0;
  endtask

  task automatic eoi(input logic sl);
    @(negedge clk) begin eoi_req = 1'b1; eoi_slave = sl; end
    @(negedge clk) eoi_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "int_out", {7'd0, int_out}, 8'h00);
    chk("R1", "vector", vector, 8'h00);
    chk("R1", "poll_data", poll_data, 8'h00);
  endtask

  task automatic t_edge_priority();
    @(negedge clk) irq_mask = 16'h0002;
    edge_line(1);
    chk("R2", "masked line 1", {7'd0, int_out}, 8'h00);
    @(negedge clk) irq_mask = 16'h0000;
    step(1);
    chk("R2", "unmasked line 1", {7'd0, int_out}, 8'h01);
    ack();
    chk("R5", "vector line 1", vector, 8'h21);
    chk("R5", "request cleared", {7'd0, int_out}, 8'h00);
    edge_line(0);
    chk("R2", "line 0 above service", {7'd0, int_out}, 8'h01);
    ack();
    chk("R5", "vector line 0", vector, 8'h20);
    edge_line(4);
    chk("R2", "line 4 blocked", {7'd0, int_out}, 8'h00);
    eoi(1'b0);
    chk("R11", "one eoi, line 1 still in service", {7'd0, int_out}, 8'h00);
    eoi(1'b0);
    chk("R11", "second eoi frees line 4", {7'd0, int_out}, 8'h01);
    ack();
    chk("R5", "vector line 4", vector, 8'h24);
    eoi(1'b0);
    chk("R11", "all retired", {7'd0, int_out}, 8'h00);
  endtask

  task automatic t_level();
    @(negedge clk) begin level_mode[3] = 1'b1; irq_in[3] = 1'b1; end
    step(1);
    chk("R3", "level pending", {7'd0, int_out}, 8'h01);
    ack();
    chk("R3", "level vector", vector, 8'h23);
    chk("R3", "in service", {7'd0, int_out}, 8'h00);
    eoi(1'b0);
    chk("R3", "level request kept", {7'd0, int_out}, 8'h01);
    @(negedge clk) irq_in[3] = 1'b0;
    step(1);
    chk("R3", "level dropped", {7'd0, int_out}, 8'h00);
    @(negedge clk) begin level_mode = 16'h0001; irq_in[0] = 1'b1; end
    step(1);
    ack();
    chk("R3", "line 0 vector", vector, 8'h20);
    eoi(1'b0);
    chk("R3", "line 0 stays edge", {7'd0, int_out}, 8'h00);
    @(negedge clk) begin irq_in[0] = 1'b0; level_mode = '0; end
  endtask

  task automatic t_cascade();
    edge_line(13);
    step(1);
    chk("R4", "secondary raises line 2", {7'd0, int_out}, 8'h01);
    ack();
    chk("R6", "cascaded vector", vector, 8'h75);
    chk("R6", "after cascade ack", {7'd0, int_out}, 8'h00);
    eoi(1'b1);
    eoi(1'b0);
    @(negedge clk) irq_in[2] = 1'b1;
    step(2);
    chk("R4", "irq_in[2] ignored", {7'd0, int_out}, 8'h00);
    @(negedge clk) irq_in[2] = 1'b0;
  endtask

  task automatic t_cascade_spurious();
    edge_line(14);
    step(1);
    @(negedge clk) irq_mask[14] = 1'b1;
    step(1);
    chk("R7", "line 2 latched", {7'd0, int_out}, 8'h01);
    ack();
    chk("R7", "spurious secondary vector", vector, 8'h77);
    eoi(1'b0);
    @(negedge clk) irq_mask[14] = 1'b0;
    step(2);
    chk("R7", "secondary request kept", {7'd0, int_out}, 8'h01);
    ack();
    chk("R7", "secondary line 6 vector", vector, 8'h76);
    eoi(1'b1);
    eoi(1'b0);
    chk("R11", "idle after cascade", {7'd0, int_out}, 8'h00);
  endtask

  task automatic t_master_spurious();
    ack();
    chk("R8", "spurious primary vector", vector, 8'h27);
    chk("R8", "no request", {7'd0, int_out}, 8'h00);
  endtask

  task automatic t_hold();
    edge_line(5);
    step(3);
    chk("R9", "vector held", vector, 8'h27);
    chk("R9", "line 5 pending", {7'd0, int_out}, 8'h01);
    ack();
    chk("R9", "vector updates on ack", vector, 8'h25);
    eoi(1'b0);
  endtask

  task automatic t_poll();
    edge_line(5);
    poll(1'b0);
    chk("R10", "poll line 5", poll_data, 8'h85);
    chk("R10", "request cleared", {7'd0, int_out}, 8'h00);
    edge_line(6);
    chk("R10", "not left in service", {7'd0, int_out}, 8'h01);
    poll(1'b0);
    chk("R10", "poll line 6", poll_data, 8'h86);
    poll(1'b0);
    chk("R10", "poll empty", poll_data, 8'h07);
    edge_line(11);
    step(1);
    chk("R10", "secondary pending", {7'd0, int_out}, 8'h01);
    poll(1'b1);
    chk("R10", "poll secondary line 3", poll_data, 8'h83);
    step(2);
    chk("R10", "line 2 cleared", {7'd0, int_out}, 8'h00);
  endtask

  task automatic t_precedence();
    edge_line(1);
    @(negedge clk) begin ack_req = 1'b1; poll_req = 1'b1; poll_slave = 1'b0; end
    @(negedge clk) begin ack_req = 1'b0; poll_req = 1'b0; end
    chk("R12", "ack wins", vector, 8'h21);
    chk("R12", "poll ignored", poll_data, 8'h83);
    @(negedge clk) begin poll_req = 1'b1; eoi_req = 1'b1; eoi_slave = 1'b0; end
    @(negedge clk) begin poll_req = 1'b0; eoi_req = 1'b0; end
    chk("R12", "eoi ignored, poll empty", poll_data, 8'h07);
    edge_line(2 + 1);
    chk("R12", "line 1 still in service", {7'd0, int_out}, 8'h00);
    eoi(1'b0);
    chk("R12", "line 3 after eoi", {7'd0, int_out}, 8'h01);
    ack();
    eoi(1'b0);
  endtask

  initial begin
    step(3);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_edge_priority();
    t_level();
    t_cascade();
    t_cascade_spurious();
    t_master_spurious();
    t_hold();
    t_poll();
    t_precedence();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule